// File: doc/BRIEF.md
# Dual-Prescaler Pulse-Width Modulator

This block produces one pulse-width modulated output from a single source clock. Software programs three registers over a simple write strobe. A control word turns the generator on and picks the clock division. A period word sets how many divided ticks make up one cycle of the waveform. A threshold word sets how many of those ticks the output stays high.

The division chain has two stages in series. The first stage is an optional fixed divide-by-1625, which gives very long periods, down to the rate used for blinking an LED. The second stage is a power-of-two divider whose exponent comes from the control word. Each divided tick advances a 13-bit period counter. The output is high while that count is below the threshold.

Values written while the generator runs wait in staging registers. They move into the working copies only when the counter wraps, so a change never cuts a pulse short.

Top module: `pwm_dual_prescale`

## Requirements
- R1: A synchronous active-high reset clears all registers and counters, and drives `pwm_out` low.
- R2: Writes are decoded by address. Address 0 is control: bit 15 is enable, bit 3 selects the extra divide-by-1625 stage, and bits 2:0 hold the exponent. Address 1 is the period (bits 12:0). Address 2 is the threshold (bits 13:0).
- R3: With the select bit clear, the counter advances once every 2^exponent source clocks, for exponents 0 to 7.
- R4: With the select bit set, the counter advances once every 1625 × 2^exponent source clocks.
- R5: The counter runs from 0 up to and including the period value, then returns to 0. One waveform cycle is therefore (period+1) ticks, up to a period value of 8191.
- R6: `pwm_out` is a registered output. In each cycle it equals the result of (count < threshold) taken one source clock earlier.
- R7: A threshold of 0 keeps the output low at all times. A threshold greater than the period keeps it high at all times.
- R8: While enable is clear, the output is low from the second cycle after the clearing write. The counter and both prescaler stages are held at zero. Settings written while disabled apply from the first cycle after enable is set.
- R9: Period, threshold and divider values written while running take effect only at the wrap. Both prescaler stages restart at the wrap, so the first tick of the new setting is fully aligned.
- R10: A write to address 3 has no effect on the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address |
| wr_data | input | 16 | Register write data |
| pwm_out | output | 1 | Modulated output, registered |

## Verification
The hardest case to reach is a settings change while the generator runs. The new values must wait until the wrap, and the prescaler must restart exactly there.

The bench enables a slow configuration, then rewrites the period, the threshold and the divider exponent a few cycles into the first period. It compares every cycle against an arithmetic model that switches formulas at the computed wrap cycle.

The long divide-by-1625 path is covered by complete periods, and the 13-bit maximum period is run for a full cycle.

// File: rtl/pwm_dp_pkg.sv
package pwm_dp_pkg;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_PER  = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_THR  = 2'd2;
  localparam int CTRL_EN_BIT  = 15;
  localparam int CTRL_SEL_BIT = 3;
endpackage

// File: rtl/pwm_dp_regs.sv
module pwm_dp_regs
  import pwm_dp_pkg::*;
#(
  parameter int CNT_W = 13,
  parameter int THR_W = 14,
  parameter int EXP_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              reload,
  output logic              run,
  output logic [CNT_W-1:0]  act_per,
  output logic [THR_W-1:0]  act_thr,
  output logic [EXP_W-1:0]  act_exp,
  output logic              act_sel
);
  logic             stg_en, stg_sel;
  logic [EXP_W-1:0] stg_exp;
  logic [CNT_W-1:0] stg_per;
  logic [THR_W-1:0] stg_thr;

  logic             nxt_en, nxt_sel;
  logic [EXP_W-1:0] nxt_exp;
  logic [CNT_W-1:0] nxt_per;
  logic [THR_W-1:0] nxt_thr;

  always_comb begin
    nxt_en  = stg_en;
    nxt_sel = stg_sel;
    nxt_exp = stg_exp;
    nxt_per = stg_per;
    nxt_thr = stg_thr;
    if (wr_en) begin
      unique case (wr_addr)
        ADDR_CTRL: begin
          nxt_en  = wr_data[CTRL_EN_BIT];
          nxt_sel = wr_data[CTRL_SEL_BIT];
          nxt_exp = wr_data[EXP_W-1:0];
        end
        ADDR_PER: nxt_per = wr_data[CNT_W-1:0];
        ADDR_THR: nxt_thr = wr_data[THR_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stg_en  <= 1'b0;
      stg_sel <= 1'b0;
      stg_exp <= '0;
      stg_per <= '0;
      stg_thr <= '0;
    end else begin
      stg_en  <= nxt_en;
      stg_sel <= nxt_sel;
      stg_exp <= nxt_exp;
      stg_per <= nxt_per;
      stg_thr <= nxt_thr;
    end
  end

  // Working copies follow staging while idle, otherwise only at the wrap
  always_ff @(posedge clk) begin
    if (rst) begin
      act_sel <= 1'b0;
      act_exp <= '0;
      act_per <= '0;
      act_thr <= '0;
    end else if (!stg_en || reload) begin
      act_sel <= nxt_sel;
      act_exp <= nxt_exp;
      act_per <= nxt_per;
      act_thr <= nxt_thr;
    end
  end

  assign run = stg_en;

  AST_ACT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (stg_en && !reload) |=> ($stable(act_per) && $stable(act_thr) && $stable(act_exp) && $stable(act_sel))); // R9
endmodule

// File: rtl/pwm_dp_prescaler.sv
module pwm_dp_prescaler #(
  parameter int EXP_W   = 3,
  parameter int FIX_DIV = 1625
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic             sel,
  input  logic [EXP_W-1:0] exp_sel,
  output logic             tick
);
  localparam int FIX_W = $clog2(FIX_DIV);
  localparam int POW_W = (1 << EXP_W) - 1;
  localparam logic [FIX_W-1:0] FIX_LAST = FIX_W'(FIX_DIV - 1);

  logic [FIX_W-1:0] fix_cnt;
  logic [POW_W-1:0] pow_cnt;
  logic [POW_W-1:0] mask;
  logic             fix_pulse;
  logic             pow_hit;

  assign fix_pulse = sel ? (fix_cnt == FIX_LAST) : 1'b1;

  always_ff @(posedge clk) begin
    if (rst || restart || !sel) begin
      fix_cnt <= '0;
    end else if (fix_cnt == FIX_LAST) begin
      fix_cnt <= '0;
    end else begin
      fix_cnt <= fix_cnt + 1'b1;
    end
  end

  for (genvar i = 0; i < POW_W; i++) begin : g_mask
    localparam logic [EXP_W:0] IDX = (EXP_W+1)'(i);
    assign mask[i] = IDX < {1'b0, exp_sel};
  end

  assign pow_hit = &(pow_cnt | ~mask);

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      pow_cnt <= '0;
    end else if (fix_pulse) begin
      pow_cnt <= pow_cnt + 1'b1;
    end
  end

  assign tick = fix_pulse && pow_hit;

  AST_FIX_RANGE: assert property (@(posedge clk) disable iff (rst)
    fix_cnt <= FIX_LAST); // R4
  AST_TICK_SPACED: assert property (@(posedge clk) disable iff (rst)
    (tick && !restart && (exp_sel != '0 || sel)) |=> !tick); // R3
endmodule

// File: rtl/pwm_dp_counter.sv
module pwm_dp_counter #(
  parameter int CNT_W = 13,
  parameter int THR_W = 14
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             tick,
  input  logic [CNT_W-1:0] per,
  input  logic [THR_W-1:0] thr,
  output logic             wrap,
  output logic             pwm_out
);
  logic [CNT_W-1:0] cnt;

  assign wrap = run && tick && (cnt == per);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
    end else if (tick) begin
      cnt <= wrap ? '0 : cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pwm_out <= 1'b0;
    end else begin
      pwm_out <= run && ({{(THR_W-CNT_W){1'b0}}, cnt} < thr);
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    run |-> (cnt <= per)); // R5
  AST_OFF_LOW: assert property (@(posedge clk) disable iff (rst)
    !run |=> !pwm_out); // R8
  AST_ZERO_THR: assert property (@(posedge clk) disable iff (rst)
    (run && thr == '0) |=> !pwm_out); // R7
  AST_FULL_THR: assert property (@(posedge clk) disable iff (rst)
    (run && thr > {1'b0, per}) |=> pwm_out); // R7
endmodule

// File: rtl/pwm_dual_prescale.sv
module pwm_dual_prescale
  import pwm_dp_pkg::*;
#(
  parameter int CNT_W   = 13,
  parameter int EXP_W   = 3,
  parameter int FIX_DIV = 1625
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              pwm_out
);
  localparam int THR_W = CNT_W + 1;

  logic             run, act_sel, tick, wrap;
  logic [CNT_W-1:0] act_per;
  logic [THR_W-1:0] act_thr;
  logic [EXP_W-1:0] act_exp;

  pwm_dp_regs #(.CNT_W(CNT_W), .THR_W(THR_W), .EXP_W(EXP_W)) regs_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .reload(wrap), .run(run), .act_per(act_per), .act_thr(act_thr),
    .act_exp(act_exp), .act_sel(act_sel)
  );

  pwm_dp_prescaler #(.EXP_W(EXP_W), .FIX_DIV(FIX_DIV)) presc_i (
    .clk(clk), .rst(rst), .restart(!run || wrap), .sel(act_sel),
    .exp_sel(act_exp), .tick(tick)
  );

  pwm_dp_counter #(.CNT_W(CNT_W), .THR_W(THR_W)) cnt_i (
    .clk(clk), .rst(rst), .run(run), .tick(tick), .per(act_per),
    .thr(act_thr), .wrap(wrap), .pwm_out(pwm_out)
  );

  AST_RST_LOW: assert property (@(posedge clk) rst |=> !pwm_out); // R1
endmodule

// File: tb/pwm_dual_prescale_tb_top.sv
module pwm_dual_prescale_tb_top;
  localparam int FIX_DIV = 1625;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        pwm_out;
  int vectors = 0;
  int miscompares = 0;

  always #5 clk = ~clk;

  pwm_dual_prescale dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .pwm_out(pwm_out)
  );

  task automatic chk(string tag, logic expv);
    vectors++;
    if (pwm_out !== expv) begin
      miscompares++;
      $display("FAIL %s: pwm_out=%0b expected %0b at %0t", tag, pwm_out, expv, $time);
    end
  endtask

  // called at a negedge; returns at the negedge after the write edge
  task automatic wr(logic [1:0] a, logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic logic [15:0] ctl(bit en, bit sel, int e);
    logic [15:0] v = '0;
    v[15] = en; v[3] = sel; v[2:0] = 3'(e);
    return v;
  endfunction

  // cycle c counts from the first cycle after the enabling write edge
  function automatic logic model(int c, int d, int p, int t);
    if (c <= 0) return 1'b0;
    return (((c - 1) / d) % (p + 1)) < t;
  endfunction

  task automatic run_cfg(string tag, int e, bit sel, int p, int t, int n);
    int d = (1 << e) * (sel ? FIX_DIV : 1);
    wr(2'd0, ctl(0, 0, 0));
    wr(2'd1, 16'(p));
    wr(2'd2, 16'(t));
    wr(2'd0, ctl(1, sel, e));
    for (int c = 0; c < n; c++) begin
      chk(tag, model(c, d, p, t));
      @(negedge clk);
    end
  endtask

  initial begin
    int plist [4] = '{0, 1, 3, 5};
    repeat (3) @(negedge clk);
    chk("R1", 1'b0);
    rst = 1'b0;
    for (int i = 0; i < 4; i++) begin
      chk("R1", 1'b0);
      @(negedge clk);
    end

    // sweep exponent, period and every threshold up to period+1
    for (int e = 0; e < 4; e++)
      for (int pi = 0; pi < 4; pi++)
        for (int t = 0; t <= plist[pi] + 1; t++)
          run_cfg((t == 0 || t > plist[pi]) ? "R7" : "R3/R5/R6/R2",
                  e, 0, plist[pi], t, 2 * (plist[pi] + 1) * (1 << e) + 2);

    run_cfg("R3", 7, 0, 1, 1, 4 * 128 + 2);
    run_cfg("R4", 0, 1, 2, 1, 2 * 3 * FIX_DIV + 2);
    run_cfg("R4", 1, 1, 1, 1, 2 * 2 * 2 * FIX_DIV + 2);
    run_cfg("R5", 0, 0, 8191, 8191, 8194);
    run_cfg("R7", 0, 0, 8191, 8192, 8200);

    // R8: disable while running with a full threshold
    run_cfg("R8", 0, 0, 3, 9, 10);
    wr(2'd0, ctl(0, 0, 0));
    @(negedge clk);
    for (int c = 0; c < 20; c++) begin
      chk("R8", 1'b0);
      @(negedge clk);
    end

    // R9: mid-period rewrite of period, threshold and exponent
    wr(2'd1, 16'd5);
    wr(2'd2, 16'd3);
    wr(2'd0, ctl(1, 0, 1));
    for (int c = 0; c < 40; c++) begin
      chk("R9/R2", (c - 1 < 12) ? model(c, 2, 5, 3) : model(c - 12, 1, 2, 2));
      wr_en = 1'b0;
      if (c == 1) begin wr_en = 1'b1; wr_addr = 2'd1; wr_data = 16'd2; end
      if (c == 2) begin wr_en = 1'b1; wr_addr = 2'd2; wr_data = 16'd2; end
      if (c == 3) begin wr_en = 1'b1; wr_addr = 2'd0; wr_data = ctl(1, 0, 0); end
      @(negedge clk);
    end
    wr_en = 1'b0;

    // R10: address 3 write while running changes nothing
    wr(2'd0, ctl(0, 0, 0));
    wr(2'd1, 16'd3);
    wr(2'd2, 16'd2);
    wr(2'd0, ctl(1, 0, 0));
    for (int c = 0; c < 30; c++) begin
      chk("R10", model(c, 1, 3, 2));
      wr_en = (c == 2);
      wr_addr = 2'd3;
      wr_data = 16'h0000;
      @(negedge clk);
    end
    wr_en = 1'b0;

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule